// File: doc/BRIEF.md
# Sense-Amplifier Offset Search Controller

This block characterizes an array of sense-amplifier test cells, one cell at a time. For each cell it ramps a differential input step code upward from zero and finds the lowest code at which the cell resolves correctly. The step code goes to an external divider tap selector. The addressed cell is exercised through a per-row gated sense strobe and a per-column input enable, so no other cell in the array can switch. The controller watches the cell's single digital output and stores the first passing code in an internal result memory, indexed by cell address.

Each trial runs in a fixed order. First the strobe is held low for a settle window while the new code reaches the divider output and the cell precharges. Then the strobe is held high for a programmable number of cycles, and the cell output is sampled in the last of those cycles. A sampled 0 is a pass and a sampled 1 is a fail. If a cell never passes up to the configured ceiling code, the controller stores the ceiling code with an overflow flag. A start pulse launches a sweep over all 512 cells. The array is two 16x16 halves, addressed by a 5-bit row and a 4-bit column. At the end of the sweep the controller raises a single-cycle done.

Top module: `ofs_search_top`

## Requirements
- R1: After reset, and whenever no sweep is running, busy and done are 0, every bit of senseEn and inEn is 0, and stepCode is 0.
- R2: At most one senseEn bit and at most one inEn bit are high at any time. While strobing, senseEn has only bit rowAddr set. While busy, inEn has only bit colAddr set.
- R3: The first trial of every cell uses stepCode 0. Each trial that samples a 1 raises stepCode by exactly one for the next trial of the same cell.
- R4: Before each strobe rises, senseEn stays low for at least SETTLE_CYC cycles with the current stepCode and cell address unchanged.
- R5: Each strobe stays high for holdCycles cycles, where a value of 0 acts as 1. The cell output is sampled in the final high cycle, and stepCode is stable while the strobe is high.
- R6: When a trial samples 0, the entry at cell address {row,col} (row in the upper 5 bits, column in the lower 4) receives the current stepCode with the overflow bit (bit STEP_W) clear.
- R7: When a trial samples 1 at stepCode STEP_MAX, the entry receives STEP_MAX with the overflow bit set, and the controller moves on.
- R8: Cells are visited in increasing address order from 0 to 511, one after another.
- R9: After the last cell's result, done is high for exactly one cycle and busy falls. The controller then stays idle until the next start.
- R10: rdData returns the result memory entry at rdAddr one cycle after rdAddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a sweep while idle |
| holdCycles | input | 8 | Strobe-high length in cycles (0 acts as 1), captured at start |
| cellOut | input | 1 | Digital output of the addressed test cell |
| rdAddr | input | 9 | Result memory read address |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| rowAddr | output | 5 | Row of the cell under test |
| colAddr | output | 4 | Column of the cell under test |
| senseEn | output | 32 | Per-row gated sense strobe |
| inEn | output | 16 | Per-column differential input enable |
| stepCode | output | 5 | Divider tap code for the current trial |
| rdData | output | 6 | Result entry: overflow flag in bit 5, step code below |

## Verification
The hardest cases to reach are the overflow path and a pass at exactly the ceiling code. Both need a cell that keeps failing for sixteen full settle-and-strobe trials. The bench models each cell as a threshold code and seeds some cells with thresholds above the ceiling. It also places directed thresholds of 0, STEP_MAX and STEP_MAX+1 on the first cells and a ceiling threshold on the last cell. The cell model also stays at 1 until the strobe has been high for the full hold length, so a design that samples early shows up as extra trials.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCell;   // return cell pointer to 0
    logic incCell;   // advance to next cell
    logic clrStep;   // restart the ramp at 0
    logic incStep;   // next ramp step
    logic wrRes;     // store result for current cell
    logic wrOvf;     // result is saturated
    logic strobeOn;  // sense strobe phase
    logic drive;     // inputs applied to the selected column
  } ofsCmd_t;
endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
#(
  parameter int HOLD_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic              cellOut,
  input  logic              stepAtMax,
  input  logic              lastCell,
  output ofsCmd_t           cmd,
  output logic              busy,
  output logic              done
);
  localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_STROBE} state_t;

  state_t            state, stateN;
  logic [SET_W-1:0]  settleCnt, settleCntN;
  logic [HOLD_W-1:0] holdCnt, holdCntN, holdReg, holdEff;
  logic              doneN;

  assign holdEff = (holdReg == '0) ? HOLD_W'(1) : holdReg;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stateN     = state;
    settleCntN = settleCnt;
    holdCntN   = holdCnt;
    doneN      = 1'b0;
    cmd        = '0;
    cmd.drive    = (state != ST_IDLE);
    cmd.strobeOn = (state == ST_STROBE);
    unique case (state)
      ST_IDLE: if (start) begin
        cmd.clrCell = 1'b1;
        cmd.clrStep = 1'b1;
        settleCntN  = '0;
        stateN      = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleCnt == SET_LAST) begin
          holdCntN = '0;
          stateN   = ST_STROBE;
        end else begin
          settleCntN = settleCnt + 1'b1;
        end
      end
      ST_STROBE: begin
        if (holdCnt == holdEff - 1'b1) begin
          settleCntN = '0;
          if (cellOut && !stepAtMax) begin
            cmd.incStep = 1'b1;
            stateN      = ST_SETTLE;
          end else begin
            cmd.wrRes   = 1'b1;
            cmd.wrOvf   = cellOut;
            cmd.clrStep = 1'b1;
            if (lastCell) begin
              cmd.clrCell = 1'b1;
              doneN       = 1'b1;
              stateN      = ST_IDLE;
            end else begin
              cmd.incCell = 1'b1;
              stateN      = ST_SETTLE;
            end
          end
        end else begin
          holdCntN = holdCnt + 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      holdCnt   <= '0;
      holdReg   <= '0;
      done      <= 1'b0;
    end else begin
      state     <= stateN;
      settleCnt <= settleCntN;
      holdCnt   <= holdCntN;
      done      <= doneN;
      if (state == ST_IDLE && start) holdReg <= holdCycles;
    end
  end

  // R9: completion pulse lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: no activity in the cycle after done
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath
  import ofs_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int COL_W    = 4,
  parameter int STEP_W   = 5,
  parameter int STEP_MAX = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ofsCmd_t                 cmd,
  input  logic [ROW_W+COL_W-1:0]  rdAddr,
  output logic                    stepAtMax,
  output logic                    lastCell,
  output logic [ROW_W-1:0]        rowAddr,
  output logic [COL_W-1:0]        colAddr,
  output logic [(1<<ROW_W)-1:0]   senseEn,
  output logic [(1<<COL_W)-1:0]   inEn,
  output logic [STEP_W-1:0]       stepCode,
  output logic [STEP_W:0]         rdData
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CELLS  = 1 << ADDR_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;

  logic [ADDR_W-1:0] cellIdx;
  logic [STEP_W:0]   resMem [CELLS];

  assign rowAddr   = cellIdx[ADDR_W-1:COL_W];
  assign colAddr   = cellIdx[COL_W-1:0];
  assign stepAtMax = (stepCode == STEP_W'(STEP_MAX));
  assign lastCell  = (cellIdx == ADDR_W'(CELLS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellIdx  <= '0;
      stepCode <= '0;
    end else begin
      if (cmd.clrCell)      cellIdx <= '0;
      else if (cmd.incCell) cellIdx <= cellIdx + 1'b1;
      if (cmd.clrStep)      stepCode <= '0;
      else if (cmd.incStep) stepCode <= stepCode + 1'b1;
    end
  end

  // Row strobe gating: only the addressed row ever sees the strobe
  for (genvar r = 0; r < ROWS; r++) begin : g_rowGate
    assign senseEn[r] = cmd.strobeOn && (rowAddr == ROW_W'(r));
  end
  // Column input gating: unselected columns held at zero
  for (genvar c = 0; c < COLS; c++) begin : g_colGate
    assign inEn[c] = cmd.drive && (colAddr == COL_W'(c));
  end

  always_ff @(posedge clk) begin
    if (cmd.wrRes) resMem[cellIdx] <= {cmd.wrOvf, stepCode};
    rdData <= resMem[rdAddr];
  end

  // R2: a single cell active at most
  assert_one_cell_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(senseEn) && $onehot0(inEn));
  // R3: ramp moves up by one or restarts at zero
  assert_step_ramp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stepCode != $past(stepCode)) |-> (stepCode == $past(stepCode) + 1'b1 || stepCode == '0));
  // R4: code changes only while the strobe is low
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepCode != $past(stepCode)) |-> (senseEn == '0));
  // R5: code stable across a strobe
  assert_step_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.strobeOn && $past(cmd.strobeOn)) |-> $stable(stepCode));
  // R7: saturated writes carry the ceiling code
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrRes && cmd.wrOvf) |-> stepAtMax);
endmodule

// File: rtl/ofs_search_top.sv
module ofs_search_top
  import ofs_pkg::*;
#(
  parameter int ROW_W      = 5,
  parameter int COL_W      = 4,
  parameter int STEP_W     = 5,
  parameter int STEP_MAX   = 15,
  parameter int HOLD_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [HOLD_W-1:0]        holdCycles,
  input  logic                     cellOut,
  input  logic [ROW_W+COL_W-1:0]   rdAddr,
  output logic                     busy,
  output logic                     done,
  output logic [ROW_W-1:0]         rowAddr,
  output logic [COL_W-1:0]         colAddr,
  output logic [(1<<ROW_W)-1:0]    senseEn,
  output logic [(1<<COL_W)-1:0]    inEn,
  output logic [STEP_W-1:0]        stepCode,
  output logic [STEP_W:0]          rdData
);
  ofsCmd_t cmd;
  logic    stepAtMax, lastCell;

  ofs_ctrl #(.HOLD_W(HOLD_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk, .rstN, .start, .holdCycles, .cellOut,
    .stepAtMax, .lastCell, .cmd, .busy, .done
  );

  ofs_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .STEP_W(STEP_W), .STEP_MAX(STEP_MAX)) u_dp (
    .clk, .rstN, .cmd, .rdAddr, .stepAtMax, .lastCell,
    .rowAddr, .colAddr, .senseEn, .inEn, .stepCode, .rdData
  );

  // R1: idle array is fully quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (senseEn == '0 && inEn == '0 && stepCode == '0));
endmodule

// File: tb/ofs_search_top_bench.sv
module ofs_search_top_bench;
  localparam int ROWS = 32, COLS = 16, CELLS = 512;
  localparam int STEP_MAX = 15, SETTLE = 4;

  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0, cellOut = 1'b1;
  logic [7:0]  holdCycles = 8'd3;
  logic [8:0]  rdAddr = '0;
  logic        busy, done;
  logic [4:0]  rowAddr;
  logic [3:0]  colAddr;
  logic [31:0] senseEn;
  logic [15:0] inEn;
  logic [4:0]  stepCode;
  logic [5:0]  rdData;

  ofs_search_top u_ofs_search_top (
    .clk, .rstN, .start, .holdCycles, .cellOut, .rdAddr,
    .busy, .done, .rowAddr, .colAddr, .senseEn, .inEn, .stepCode, .rdData
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int thr [CELLS];
  int trialsSeen [CELLS];
  int holdEff = 3;
  int r2Bad, r3Bad, r4Bad, r5Bad, r8Bad, doneCnt;
  int quiet, highCnt, k, lastCell, prevStep, prevCell;
  bit prevAny, runFirst;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRes(int t);
    return (t > STEP_MAX) ? (32 | STEP_MAX) : t;
  endfunction

  function automatic int expTrials(int t);
    return ((t > STEP_MAX) ? STEP_MAX : t) + 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Monitor and cell model, evaluated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      automatic bit anySe = |senseEn;
      automatic int cellNow = {rowAddr, colAddr};
      automatic int selR = -1, selC = -1;
      if ($countones(senseEn) > 1 || $countones(inEn) > 1) r2Bad++;
      if (anySe && (senseEn != (32'd1 << rowAddr) || inEn != (16'd1 << colAddr))) r2Bad++;
      if (busy && inEn != (16'd1 << colAddr)) r2Bad++;
      if (!busy && (inEn != '0 || anySe)) r2Bad++;
      if (done) doneCnt++;
      if (!busy) quiet = 0;
      else if (!anySe) begin
        if (int'(stepCode) != prevStep || cellNow != prevCell) quiet = 1;
        else quiet++;
      end
      if (anySe && !prevAny) begin
        if (quiet < SETTLE) r4Bad++;
        if (runFirst || cellNow != lastCell) begin
          if (cellNow != (runFirst ? 0 : lastCell + 1)) r8Bad++;
          k = 0;
          runFirst = 0;
        end else k++;
        if (int'(stepCode) != k) r3Bad++;
        trialsSeen[cellNow] = k + 1;
        lastCell = cellNow;
      end
      if (anySe) highCnt++;
      else begin
        if (prevAny && highCnt != holdEff) r5Bad++;
        highCnt = 0;
      end
      for (int r = 0; r < ROWS; r++) if (senseEn[r]) selR = r;
      for (int c = 0; c < COLS; c++) if (inEn[c]) selC = c;
      if (selR >= 0 && selC >= 0 && highCnt >= holdEff && int'(stepCode) >= thr[selR*COLS + selC])
        cellOut = 1'b0;
      else
        cellOut = 1'b1;
      prevAny  = anySe;
      prevStep = int'(stepCode);
      prevCell = cellNow;
    end
  end

  task automatic runSweep(int hold, string tag);
    int passBad = 0, ovfBad = 0, trBad = 0;
    r2Bad = 0; r3Bad = 0; r4Bad = 0; r5Bad = 0; r8Bad = 0; doneCnt = 0;
    for (int i = 0; i < CELLS; i++) trialsSeen[i] = 0;
    holdEff = (hold == 0) ? 1 : hold;
    holdCycles = 8'(hold);
    runFirst = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (doneCnt == 0) @(negedge clk);
    repeat (30) @(negedge clk);
    check(doneCnt == 1, {"R9 done pulses ", tag}, doneCnt, 1);
    check(!busy && senseEn == '0 && inEn == '0 && stepCode == '0,
          {"R9/R1 idle after sweep ", tag}, int'(busy), 0);
    check(r2Bad == 0, {"R2 single active cell ", tag}, r2Bad, 0);
    check(r3Bad == 0, {"R3 ramp from zero by one ", tag}, r3Bad, 0);
    check(r4Bad == 0, {"R4 settle before strobe ", tag}, r4Bad, 0);
    check(r5Bad == 0, {"R5 strobe length ", tag}, r5Bad, 0);
    check(r8Bad == 0 && lastCell == CELLS - 1, {"R8 cell order ", tag}, lastCell, CELLS - 1);
    for (int i = 0; i < CELLS; i++) begin
      rdAddr = 9'(i);
      @(negedge clk);
      if (trialsSeen[i] != expTrials(thr[i])) trBad++;
      if (thr[i] > STEP_MAX) begin
        if (int'(rdData) != expRes(thr[i])) ovfBad++;
      end else if (int'(rdData) != expRes(thr[i])) passBad++;
    end
    check(trBad == 0, {"R3 trials per cell ", tag}, trBad, 0);
    check(passBad == 0, {"R6/R10 pass results ", tag}, passBad, 0);
    check(ovfBad == 0, {"R7 saturated results ", tag}, ovfBad, 0);
  endtask

  initial begin
    void'($urandom(32'h0ff5e7));
    for (int i = 0; i < CELLS; i++) thr[i] = 0;
    repeat (4) @(negedge clk);
    check(!busy && !done && senseEn == '0 && inEn == '0 && stepCode == '0,
          "R1 reset state", int'(busy), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && senseEn == '0, "R1 idle without start", int'(busy), 0);

    // Sweep 1: random thresholds, some above the ceiling
    for (int i = 0; i < CELLS; i++) thr[i] = int'($urandom_range(0, STEP_MAX + 2));
    runSweep(3, "random");

    // Sweep 2: directed corners, zero hold acting as one
    for (int i = 0; i < CELLS; i++) thr[i] = int'($urandom_range(0, 5));
    thr[0] = 0; thr[1] = STEP_MAX; thr[2] = STEP_MAX + 1; thr[CELLS-1] = STEP_MAX;
    runSweep(0, "directed");
    rdAddr = 9'd0; @(negedge clk);
    check(rdData == 6'd0, "R6 zero threshold passes at code 0", int'(rdData), 0);
    rdAddr = 9'd1; @(negedge clk);
    check(int'(rdData) == STEP_MAX, "R6 pass exactly at ceiling", int'(rdData), STEP_MAX);
    rdAddr = 9'd2; @(negedge clk);
    check(int'(rdData) == (32 | STEP_MAX), "R7 overflow flag at ceiling+1", int'(rdData), 32 | STEP_MAX);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule